// File: doc/BRIEF.md
# Periodic Complete-Split Tracker

This block holds the decision and write-back logic for one periodic queue head whose transfer runs through a transaction translator as a split transaction. On each micro-frame strobe it looks at the current micro-frame index, the frame number and the queue head's mask, tag and recovery fields. It then decides whether a complete-split may be sent in this micro-frame. When it commits, it records the micro-frame in the progress mask.

When the translator's answer to a complete-split arrives, the block computes the updated error counter, the transaction-error flag, the halt flag and the frame tag. It also reports what the transfer should do next: stay in the complete-split phase, go back and retry the start-split, or advance. The surrounding controller writes these fields back to the queue head. The block sends no packets, walks no schedule and moves no data.

Top module: `csplit_tracker`

## Requirements
- R1: One cycle after a cycle with `uf_strobe` high, `cs_issue` is 1 exactly when four conditions all hold. (a) The one-hot micro-frame bit `1 << uf_idx` is set in `c_mask`. (b) The frame tag matches. (c) The consistency checks of R5 and R6 pass. (d) The start-split test is false. The start-split test is true when the same bit is set in `s_mask` and `recovery` is 0. In any cycle not preceded by a strobe, `cs_issue` is 0.
- R2: Condition (b) holds only when `frame_tag_in` equals `frame_num`. A mismatch blocks the complete-split.
- R3: On a strobe that issues, `c_prog_out` becomes `c_prog_in` with the current micro-frame bit ORed in. On a strobe that does not issue, it becomes `c_prog_in` unchanged. Between strobes it holds its value.
- R4: When condition (a) and the start-split test are both true, `sw_err` is 1 for one cycle after the strobe and nothing is issued. When `recovery` is 1, the start-split test is false.
- R5: The previous bit is the current one-hot bit rotated one place toward bit 0, so micro-frame 0 uses bit 7. If that bit is set in `c_mask` but clear in `c_prog_in`, no complete-split is issued.
- R6: If the current micro-frame bit is already set in `c_prog_in`, no complete-split is issued.
- R7: A response is NYET when `resp_code` is 0. The current complete-split is the last one when `c_mask` XOR `c_prog_out` is zero. A NYET on the last complete-split has these effects: `nxt_state` is 1 (retry the start-split), `xact_err` is 1, and `cerr_out` is `cerr_in` minus 1.
- R8: A NYET that is not on the last complete-split gives `nxt_state` 0 (stay). `cerr_out` equals `cerr_in`, and `xact_err` is 0.
- R9: A response that decrements the error counter from 1 to 0 sets `halt`. When `cerr_in` is 0, the counter is not decremented and `halt` stays 0.
- R10: A data response (`resp_code` 1) gives `nxt_state` 2 (advance), with `cerr_out` equal to `cerr_in` and no error flags. An error response (`resp_code` 2 or 3) gives `nxt_state` 0, sets `xact_err` and decrements the counter as in R9.
- R11: One cycle after a cycle with `resp_valid` high, `wb_valid` is 1 for one cycle and `frame_tag_out` equals `exp_frame`.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uf_strobe | input | 1 | Micro-frame evaluation strobe |
| uf_idx | input | 3 | Current micro-frame index |
| frame_num | input | 5 | Current frame number (low bits) |
| c_mask | input | 8 | Complete-split schedule mask |
| s_mask | input | 8 | Start-split schedule mask |
| c_prog_in | input | 8 | Complete-splits already sent |
| frame_tag_in | input | 5 | Stored frame tag |
| recovery | input | 1 | Recovery-path processing active |
| resp_valid | input | 1 | Translator response present |
| resp_code | input | 2 | 0 NYET, 1 data, 2/3 error |
| cerr_in | input | 2 | Current error counter |
| exp_frame | input | 5 | Expected frame number for the tag |
| cs_issue | output | 1 | Send a complete-split now |
| sw_err | output | 1 | Start-split and complete-split both scheduled |
| c_prog_out | output | 8 | Updated progress mask |
| wb_valid | output | 1 | Response write-back fields valid |
| frame_tag_out | output | 5 | Updated frame tag |
| cerr_out | output | 2 | Updated error counter |
| xact_err | output | 1 | Transaction error flag |
| halt | output | 1 | Halt the queue head |
| nxt_state | output | 2 | 0 stay, 1 retry start-split, 2 advance |

## Verification
The issue decision is tested with several kinds of pattern. A clean scheduled micro-frame is run first. Against it, the bench runs cases that differ in one condition each: a mismatched tag, a missed previous complete-split, an already-set progress bit, and a start-split scheduled together with a complete-split, once with recovery mode and once without. This shows that each test blocks the issue on its own. A mask pattern that progresses over successive micro-frames shows that the progress mask accumulates. For responses, the bench separates a NYET on a middle complete-split from a NYET on the final one, and data from error responses. Error-counter values of 3, 1 and 0 split plain decrement, halt and the no-decrement case.

// File: rtl/csplit_pkg.sv
// Shared widths, response codes and next-state encoding for the tracker.
package csplit_pkg;
    localparam int UF_W   = 3;
    localparam int NUF    = 1 << UF_W;
    localparam int FT_W   = 5;
    localparam int CERR_W = 2;

    typedef enum logic [1:0] {
        RSP_NYET = 2'd0,
        RSP_DATA = 2'd1,
        RSP_ERR  = 2'd2,
        RSP_ERR2 = 2'd3
    } resp_e;

    typedef enum logic [1:0] {
        NX_STAY    = 2'd0,
        NX_RETRY   = 2'd1,
        NX_ADVANCE = 2'd2
    } nxt_e;
endpackage

// File: rtl/uf_decode.sv
// Decodes the micro-frame index into the current one-hot bit and the
// previous micro-frame's bit (rotated one place toward bit 0, wrapping).
// Assumes NUF == 2**UF_W.
module uf_decode #(
    parameter int UF_W = 3,
    localparam int NUF = 1 << UF_W
) (
    input  logic [UF_W-1:0] idx,
    output logic [NUF-1:0]  cur_bit,
    output logic [NUF-1:0]  prev_bit
);
    // One-hot decode and wrap-around rotation.
    always_comb begin
        cur_bit  = '0;
        cur_bit[idx] = 1'b1;
        prev_bit = {cur_bit[0], cur_bit[NUF-1:1]};
    end
endmodule

// File: rtl/cs_gate.sv
// Evaluates the four gating tests for a complete-split in the current
// micro-frame. Purely combinational; the caller registers the result.
// Assumes the masks are one bit per micro-frame.
module cs_gate #(
    parameter int NUF  = 8,
    parameter int FT_W = 5
) (
    input  logic [NUF-1:0]  cur_bit,
    input  logic [NUF-1:0]  prev_bit,
    input  logic [NUF-1:0]  c_mask,
    input  logic [NUF-1:0]  s_mask,
    input  logic [NUF-1:0]  c_prog,
    input  logic [FT_W-1:0] frame_tag,
    input  logic [FT_W-1:0] frame_num,
    input  logic            recovery,
    output logic            issue,
    output logic            conflict
);
    logic t_sched, t_tag, t_consist, t_start, missed, alias_hit;

    // Individual tests and their combination.
    always_comb begin
        t_sched   = |(c_mask & cur_bit);
        t_tag     = (frame_tag == frame_num);
        missed    = (|(c_mask & prev_bit)) && !(|(c_prog & prev_bit));
        alias_hit = |(c_prog & cur_bit);
        t_consist = !missed && !alias_hit;
        t_start   = (|(s_mask & cur_bit)) && !recovery;
        conflict  = t_sched && t_start;
        issue     = t_sched && t_tag && t_consist && !t_start;
    end
endmodule

// File: rtl/resp_update.sv
// Computes write-back fields from a translator response to a complete-split.
// Assumes c_prog already contains the bit of the complete-split answered.
// A zero error counter is treated as "no limit" and is not decremented.
module resp_update #(
    parameter int NUF    = 8,
    parameter int CERR_W = 2
) (
    input  csplit_pkg::resp_e  code,
    input  logic [NUF-1:0]     c_mask,
    input  logic [NUF-1:0]     c_prog,
    input  logic [CERR_W-1:0]  cerr_in,
    output logic [CERR_W-1:0]  cerr_nx,
    output logic               xact_nx,
    output logic               halt_nx,
    output csplit_pkg::nxt_e   state_nx
);
    import csplit_pkg::*;
    logic last_cs, dec;

    // Classify the response, then apply the counter decrement if needed.
    always_comb begin
        last_cs  = ((c_mask ^ c_prog) == '0);
        dec      = 1'b0;
        xact_nx  = 1'b0;
        state_nx = NX_STAY;
        unique case (code)
            RSP_NYET: begin
                if (last_cs) begin
                    dec      = 1'b1;
                    xact_nx  = 1'b1;
                    state_nx = NX_RETRY;
                end
            end
            RSP_DATA: state_nx = NX_ADVANCE;
            default: begin
                dec     = 1'b1;
                xact_nx = 1'b1;
            end
        endcase
        cerr_nx = cerr_in;
        halt_nx = 1'b0;
        if (dec && (cerr_in != '0)) begin
            cerr_nx = cerr_in - 1'b1;
            halt_nx = (cerr_in == CERR_W'(1));
        end
    end
endmodule

// File: rtl/csplit_tracker.sv
// Complete-split tracker for one periodic split queue head. Registers the
// issue decision on each micro-frame strobe and the write-back fields on
// each response. Assumes strobe and response do not share a cycle; if they
// do, both paths update their own disjoint outputs.
module csplit_tracker
    import csplit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uf_strobe,
    input  logic [UF_W-1:0]   uf_idx,
    input  logic [FT_W-1:0]   frame_num,
    input  logic [NUF-1:0]    c_mask,
    input  logic [NUF-1:0]    s_mask,
    input  logic [NUF-1:0]    c_prog_in,
    input  logic [FT_W-1:0]   frame_tag_in,
    input  logic              recovery,
    input  logic              resp_valid,
    input  logic [1:0]        resp_code,
    input  logic [CERR_W-1:0] cerr_in,
    input  logic [FT_W-1:0]   exp_frame,
    output logic              cs_issue,
    output logic              sw_err,
    output logic [NUF-1:0]    c_prog_out,
    output logic              wb_valid,
    output logic [FT_W-1:0]   frame_tag_out,
    output logic [CERR_W-1:0] cerr_out,
    output logic              xact_err,
    output logic              halt,
    output logic [1:0]        nxt_state
);
    logic [NUF-1:0]    cur_bit, prev_bit;
    logic              issue_c, conflict_c;
    logic [CERR_W-1:0] cerr_c;
    logic              xact_c, halt_c;
    nxt_e              state_c;

    uf_decode #(.UF_W(UF_W)) u_dec (
        .idx(uf_idx), .cur_bit(cur_bit), .prev_bit(prev_bit)
    );

    cs_gate #(.NUF(NUF), .FT_W(FT_W)) u_gate (
        .cur_bit(cur_bit), .prev_bit(prev_bit), .c_mask(c_mask),
        .s_mask(s_mask), .c_prog(c_prog_in), .frame_tag(frame_tag_in),
        .frame_num(frame_num), .recovery(recovery),
        .issue(issue_c), .conflict(conflict_c)
    );

    resp_update #(.NUF(NUF), .CERR_W(CERR_W)) u_rsp (
        .code(resp_e'(resp_code)), .c_mask(c_mask), .c_prog(c_prog_out),
        .cerr_in(cerr_in), .cerr_nx(cerr_c), .xact_nx(xact_c),
        .halt_nx(halt_c), .state_nx(state_c)
    );

    // Micro-frame decision path: one-cycle pulses and the progress mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_issue   <= 1'b0;
            sw_err     <= 1'b0;
            c_prog_out <= '0;
        end else begin
            cs_issue <= uf_strobe && issue_c;
            sw_err   <= uf_strobe && conflict_c;
            if (uf_strobe)
                c_prog_out <= issue_c ? (c_prog_in | cur_bit) : c_prog_in;
        end
    end

    // Response path: capture write-back fields for one response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid      <= 1'b0;
            frame_tag_out <= '0;
            cerr_out      <= '0;
            xact_err      <= 1'b0;
            halt          <= 1'b0;
            nxt_state     <= NX_STAY;
        end else begin
            wb_valid <= resp_valid;
            if (resp_valid) begin
                frame_tag_out <= exp_frame;
                cerr_out      <= cerr_c;
                xact_err      <= xact_c;
                halt          <= halt_c;
                nxt_state     <= state_c;
            end
        end
    end

    // R1: no issue without a strobe in the cycle before
    a_r1_issue_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(uf_strobe) |-> !cs_issue);
    // R4: a scheduling conflict never issues
    a_r4_conflict_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        sw_err |-> !cs_issue);
    // R3: an issued complete-split leaves its bit in the progress mask
    a_r3_bit_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        cs_issue |-> ((c_prog_out & $past(cur_bit)) != '0));
    // R9: halt only with an exhausted counter and an error flag
    a_r9_halt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (cerr_out == '0) && xact_err);
    // R10: advancing never touches the counter
    a_r10_advance_keeps_cerr: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && $past(resp_valid) && nxt_state == NX_ADVANCE)
            |-> (cerr_out == $past(cerr_in)) && !xact_err);
    // R11: write-back pulse follows a response
    a_r11_wb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid == $past(resp_valid));
endmodule

// File: tb/csplit_tracker_bench.sv
module csplit_tracker_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uf_strobe = 1'b0;
    logic [2:0] uf_idx = '0;
    logic [4:0] frame_num = '0;
    logic [7:0] c_mask = '0, s_mask = '0, c_prog_in = '0;
    logic [4:0] frame_tag_in = '0;
    logic       recovery = 1'b0;
    logic       resp_valid = 1'b0;
    logic [1:0] resp_code = '0;
    logic [1:0] cerr_in = '0;
    logic [4:0] exp_frame = '0;
    logic       cs_issue, sw_err, wb_valid, xact_err, halt;
    logic [7:0] c_prog_out;
    logic [4:0] frame_tag_out;
    logic [1:0] cerr_out, nxt_state;
    int n_chk = 0, n_fail = 0;

    csplit_tracker u_csplit_tracker (
        .clk(clk), .rst_n(rst_n), .uf_strobe(uf_strobe), .uf_idx(uf_idx),
        .frame_num(frame_num), .c_mask(c_mask), .s_mask(s_mask),
        .c_prog_in(c_prog_in), .frame_tag_in(frame_tag_in),
        .recovery(recovery), .resp_valid(resp_valid), .resp_code(resp_code),
        .cerr_in(cerr_in), .exp_frame(exp_frame), .cs_issue(cs_issue),
        .sw_err(sw_err), .c_prog_out(c_prog_out), .wb_valid(wb_valid),
        .frame_tag_out(frame_tag_out), .cerr_out(cerr_out),
        .xact_err(xact_err), .halt(halt), .nxt_state(nxt_state)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Apply one micro-frame strobe; returns at the negedge where outputs are valid.
    task automatic do_uf(input logic [2:0] idx, input logic [7:0] cm, input logic [7:0] sm,
                         input logic [7:0] cp, input logic [4:0] tag, input logic rec);
        @(negedge clk);
        uf_idx = idx; c_mask = cm; s_mask = sm; c_prog_in = cp;
        frame_tag_in = tag; frame_num = 5'd9; recovery = rec; uf_strobe = 1'b1;
        @(negedge clk);
        uf_strobe = 1'b0;
    endtask

    // Apply one response; returns at the negedge where write-back is valid.
    task automatic do_rsp(input logic [1:0] code, input logic [1:0] ce, input logic [4:0] ef);
        @(negedge clk);
        resp_code = code; cerr_in = ce; exp_frame = ef; resp_valid = 1'b1;
        @(negedge clk);
        resp_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R12 cs_issue", cs_issue, 0);
        check("R12 sw_err", sw_err, 0);
        check("R12 c_prog_out", c_prog_out, 0);
        check("R12 wb_valid", wb_valid, 0);
        check("R12 fields", {frame_tag_out, cerr_out, xact_err, halt, nxt_state}, 0);
    endtask

    task automatic t_issue_basic;
        do_uf(3'd2, 8'b0001_1100, 8'b0000_0001, 8'h00, 5'd9, 1'b0);
        check("R1 issue", cs_issue, 1);
        check("R3 mask or", c_prog_out, 8'b0000_0100);
        @(negedge clk);
        check("R1 pulse ends", cs_issue, 0);
        check("R3 mask held", c_prog_out, 8'b0000_0100);
    endtask

    task automatic t_tag_mismatch;
        do_uf(3'd2, 8'b0001_1100, 8'h00, 8'h00, 5'd8, 1'b0);
        check("R2 tag blocks", cs_issue, 0);
        check("R3 mask unchanged", c_prog_out, 8'h00);
    endtask

    task automatic t_missed_prev;
        do_uf(3'd3, 8'b0001_1100, 8'h00, 8'h00, 5'd9, 1'b0);
        check("R5 missed blocks", cs_issue, 0);
        do_uf(3'd3, 8'b0001_1100, 8'h00, 8'b0000_0100, 5'd9, 1'b0);
        check("R5 prev done issue", cs_issue, 1);
        check("R3 accumulate", c_prog_out, 8'b0000_1100);
        do_uf(3'd0, 8'b1000_0001, 8'h00, 8'h00, 5'd9, 1'b0);
        check("R5 wrap bit7 blocks", cs_issue, 0);
    endtask

    task automatic t_alias;
        do_uf(3'd3, 8'b0001_1100, 8'h00, 8'b0000_1100, 5'd9, 1'b0);
        check("R6 alias blocks", cs_issue, 0);
        check("R6 mask kept", c_prog_out, 8'b0000_1100);
    endtask

    task automatic t_conflict;
        do_uf(3'd2, 8'b0000_0100, 8'b0000_0100, 8'h00, 5'd9, 1'b0);
        check("R4 sw_err", sw_err, 1);
        check("R4 no issue", cs_issue, 0);
        do_uf(3'd2, 8'b0000_0100, 8'b0000_0100, 8'h00, 5'd9, 1'b1);
        check("R4 recovery no err", sw_err, 0);
        check("R4 recovery issues", cs_issue, 1);
        do_uf(3'd0, 8'b0000_0100, 8'b0000_0001, 8'h00, 5'd9, 1'b0);
        check("R1 start only", {cs_issue, sw_err}, 0);
    endtask

    task automatic t_nyet_mid;
        do_uf(3'd2, 8'b0001_1100, 8'h00, 8'h00, 5'd9, 1'b0);
        do_rsp(2'd0, 2'd3, 5'd7);
        check("R11 wb_valid", wb_valid, 1);
        check("R11 tag", frame_tag_out, 7);
        check("R8 state stay", nxt_state, 0);
        check("R8 cerr kept", cerr_out, 3);
        check("R8 no xact", xact_err, 0);
        @(negedge clk);
        check("R11 wb pulse ends", wb_valid, 0);
    endtask

    task automatic t_nyet_last;
        do_uf(3'd4, 8'b0001_1100, 8'h00, 8'b0000_1100, 5'd9, 1'b0);
        check("R3 final bit", c_prog_out, 8'b0001_1100);
        do_rsp(2'd0, 2'd3, 5'd12);
        check("R7 retry", nxt_state, 1);
        check("R7 xact", xact_err, 1);
        check("R7 cerr dec", cerr_out, 2);
        check("R9 no halt", halt, 0);
        do_rsp(2'd0, 2'd1, 5'd12);
        check("R9 halt", halt, 1);
        check("R9 cerr zero", cerr_out, 0);
        do_rsp(2'd0, 2'd0, 5'd12);
        check("R9 zero not dec", cerr_out, 0);
        check("R9 zero no halt", halt, 0);
    endtask

    task automatic t_data_err;
        do_rsp(2'd1, 2'd2, 5'd3);
        check("R10 advance", nxt_state, 2);
        check("R10 data cerr", cerr_out, 2);
        check("R10 data flags", {xact_err, halt}, 0);
        check("R11 tag data", frame_tag_out, 3);
        do_rsp(2'd2, 2'd1, 5'd4);
        check("R10 err stay", nxt_state, 0);
        check("R10 err xact", xact_err, 1);
        check("R9 err halt", halt, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_issue_basic();
        t_tag_mismatch();
        t_missed_prev();
        t_alias();
        t_conflict();
        t_nyet_mid();
        t_nyet_last();
        t_data_err();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule